// File: doc/BRIEF.md
# Streaming Hamming ECC Generator

This block watches a byte-wide data stream and builds single-error-correcting, double-error-detecting parity codes over fixed-size blocks of that stream as the bytes go by, without holding the data. Every accepted byte adds its parity to a set of line-parity pairs chosen by the byte's position in the block, and adds its bits to six column-parity terms. At the last byte of a block the packed code is written into a result register.

A mode input, captured whenever the computation is restarted, picks one of two layouts. In the split layout, two codes are produced over two consecutive half-size blocks. In the joined layout, one code covers the whole double-size block and the second result stays zero. A restart pulse clears both results and the byte count. Once the last code of the chosen layout is stored, a done flag rises and the results stay frozen, whatever traffic follows, until the next restart.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset or a cycle with `clear_i` high, `code1_o` and `code2_o` read zero, `done_o` is low and the next accepted byte is byte 0 of a new computation.
- R2: In split layout (captured mode 0), on the clock edge that accepts byte 255, `code1_o` takes the code over bytes 0 to 255.
- R3: In split layout, on the clock edge that accepts byte 511, `code2_o` takes the code over bytes 256 to 511, with in-block positions counted from 0 again.
- R4: In joined layout (captured mode 1), on the edge that accepts byte 511, `code1_o` takes the code over bytes 0 to 511, and `code2_o` stays zero throughout.
- R5: Code format: for each position bit k (8 bits in split layout, 9 in joined), bit 2k+1 is the XOR of the parities of all bytes whose position has bit k set, and bit 2k the XOR over those with bit k clear. Above the line pairs sit six column terms: XOR over all bytes of data bits {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0,1,2,3}, {4,5,6,7}, lowest term first. In split layout the two top bits are 1.
- R6: While `done_o` is high and no clear arrives, `code1_o` and `code2_o` keep their values for any input traffic.
- R7: `done_o` rises on the edge that accepts byte 511 and stays high until a clear.
- R8: A byte is accepted only when `valid_i` and `byte_wide_i` are both high; other cycles change neither the count nor the codes.
- R9: A byte presented in the same cycle as `clear_i` is dropped; the following byte is byte 0.
- R10: `mode_i` is sampled only on reset or clear; changes between restarts have no effect on the layout.
- R11: A single flipped data bit makes the XOR of the clean and corrupted codes have exactly one bit set in every line pair, the odd bits spelling the byte position and column terms 1, 3 and 5 spelling the bit index; two flips in different bytes of the same bit give a syndrome that is not of that form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Restart pulse: clears results and count, samples `mode_i` |
| mode_i | input | 1 | 0: two half-size codes, 1: one full-size code |
| byte_wide_i | input | 1 | High when the data interface runs byte-wide |
| valid_i | input | 1 | Byte strobe |
| data_i | input | 8 | Streamed byte |
| code1_o | output | 2*ADDR_W+8 | First result register |
| code2_o | output | 2*ADDR_W+8 | Second result register |
| done_o | output | 1 | Final code of the layout stored |

## Verification
The bench builds the block with its default ADDR_W of 8, so half blocks are 256 bytes and the code is 24 bits wide, which puts both the split layout with its two spare bits and the joined layout that fills all 24 bits within reach. Streams run at full size with idle and word-wide gaps mixed in, so block boundaries at bytes 255 and 511, the frozen state after byte 511, a clear colliding with a byte, and a mode change between restarts are all driven. Single and double bit flips are injected into a stored stream to examine the syndrome.

// File: rtl/ecc_stream_pkg.sv
// Package: shared helpers for the streaming ECC generator.
// Assumes byte-wide data; column terms are fixed at six.
package ecc_stream_pkg;

    localparam int COL_TERMS = 6;

    // Column parity terms of one byte, lowest term first.
    function automatic logic [COL_TERMS-1:0] column_terms(input logic [7:0] d);
        logic [COL_TERMS-1:0] t;
        t[0] = d[0] ^ d[2] ^ d[4] ^ d[6];
        t[1] = d[1] ^ d[3] ^ d[5] ^ d[7];
        t[2] = d[0] ^ d[1] ^ d[4] ^ d[5];
        t[3] = d[2] ^ d[3] ^ d[6] ^ d[7];
        t[4] = d[0] ^ d[1] ^ d[2] ^ d[3];
        t[5] = d[4] ^ d[5] ^ d[6] ^ d[7];
        return t;
    endfunction

endpackage

// File: rtl/ecc_byte_counter.sv
// Module: ecc_byte_counter
// Counts accepted bytes across the full double block and flags when the
// last byte has been taken. Assumes take_i is only high for real bytes.
module ecc_byte_counter #(
    parameter int ADDR_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          take_i,
    output logic [ADDR_W:0] idx_o,
    output logic          full_o
);

    logic [ADDR_W:0] idx_q;
    logic            full_q;

    // Advance the position per accepted byte; mark full after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (take_i && !full_q) begin
            idx_q <= idx_q + 1'b1;
            if (&idx_q) begin
                full_q <= 1'b1;
            end
        end
    end

    assign idx_o  = idx_q;
    assign full_o = full_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !clear_i) |=> $stable(idx_q));

    // R1
    clear_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (idx_q == '0) && !full_q);

endmodule

// File: rtl/ecc_parity_accum.sv
// Module: ecc_parity_accum
// Running line and column parity over one block. Presents the value the
// accumulator will hold after the current byte, so the top can latch a
// finished code on the same edge. Assumes first_i marks block position 0.
module ecc_parity_accum
    import ecc_stream_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LINE_W = 2 * (ADDR_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take_i,
    input  logic                 first_i,
    input  logic [ADDR_W:0]      addr_i,
    input  logic [7:0]           data_i,
    output logic [LINE_W-1:0]    line_next_o,
    output logic [COL_TERMS-1:0] col_next_o
);

    logic                 byte_par;
    logic [LINE_W-1:0]    line_add;
    logic [LINE_W-1:0]    line_q;
    logic [COL_TERMS-1:0] col_q;

    assign byte_par = ^data_i;

    // One true/complement pair per position bit.
    for (genvar k = 0; k <= ADDR_W; k++) begin : g_pair
        assign line_add[2*k+1] = byte_par &  addr_i[k];
        assign line_add[2*k]   = byte_par & ~addr_i[k];
    end

    // Fold the current byte into the running terms, restarting at position 0.
    always_comb begin
        line_next_o = (first_i ? '0 : line_q) ^ line_add;
        col_next_o  = (first_i ? '0 : col_q) ^ column_terms(data_i);
    end

    // Keep the running terms for the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            col_q  <= '0;
        end else if (take_i) begin
            line_q <= line_next_o;
            col_q  <= col_next_o;
        end
    end

endmodule

// File: rtl/ecc_stream_gen.sv
// Module: ecc_stream_gen (top)
// Builds SEC-DED parity codes over streamed bytes, either two codes over
// half blocks or one code over the full block, freezing the results once
// the last one is stored. Assumes mode_i is only meaningful at restart.
module ecc_stream_gen
    import ecc_stream_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LINE_W = 2 * (ADDR_W + 1),
    localparam int CODE_W = 2 * ADDR_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              mode_i,
    input  logic              byte_wide_i,
    input  logic              valid_i,
    input  logic [7:0]        data_i,
    output logic [CODE_W-1:0] code1_o,
    output logic [CODE_W-1:0] code2_o,
    output logic              done_o
);

    logic                 joined_q;
    logic                 take;
    logic [ADDR_W:0]      idx;
    logic [ADDR_W:0]      addr;
    logic                 first_pos;
    logic                 last_pos;
    logic [LINE_W-1:0]    line_next;
    logic [COL_TERMS-1:0] col_next;
    logic [CODE_W-1:0]    packed_code;
    logic [CODE_W-1:0]    code1_q;
    logic [CODE_W-1:0]    code2_q;

    // Sample the layout only when a computation restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            joined_q <= mode_i;
        end
    end

    assign take = valid_i && byte_wide_i && !clear_i && !done_o;

    ecc_byte_counter #(.ADDR_W(ADDR_W)) counter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .take_i  (take),
        .idx_o   (idx),
        .full_o  (done_o)
    );

    // Position inside the current block and its boundaries.
    always_comb begin
        if (joined_q) begin
            addr      = idx;
            first_pos = (idx == '0);
            last_pos  = &idx;
        end else begin
            addr      = {1'b0, idx[ADDR_W-1:0]};
            first_pos = (idx[ADDR_W-1:0] == '0);
            last_pos  = &idx[ADDR_W-1:0];
        end
    end

    ecc_parity_accum #(.ADDR_W(ADDR_W)) accum_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .first_i     (first_pos),
        .addr_i      (addr),
        .data_i      (data_i),
        .line_next_o (line_next),
        .col_next_o  (col_next)
    );

    // Pack line pairs low, column terms above, spare ones on top if split.
    always_comb begin
        if (joined_q) begin
            packed_code = {col_next, line_next};
        end else begin
            packed_code = {2'b11, col_next, line_next[LINE_W-3:0]};
        end
    end

    // Store a finished code in the slot its block belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            code1_q <= '0;
            code2_q <= '0;
        end else if (take && last_pos) begin
            if (joined_q || !idx[ADDR_W]) begin
                code1_q <= packed_code;
            end else begin
                code2_q <= packed_code;
            end
        end
    end

    assign code1_o = code1_q;
    assign code2_o = code2_q;

    // R6
    result_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> ($stable(code1_o) && $stable(code2_o)));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> done_o);

    // R4
    joined_slot2_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (joined_q && !clear_i) |=> (code2_o == '0));

    // R1
    clear_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (code1_o == '0) && (code2_o == '0) && !done_o);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> $stable(joined_q));

endmodule

// File: tb/ecc_stream_gen_tb_top.sv
module ecc_stream_gen_tb_top;

    localparam int AW = 8;
    localparam int CW = 2 * AW + 8;
    localparam int NB = 2 ** (AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          mode = 1'b0;
    logic          bw = 1'b1;
    logic          valid = 1'b0;
    logic [7:0]    data = 8'h00;
    logic [CW-1:0] c1;
    logic [CW-1:0] c2;
    logic          done;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [NB];

    always #5 clk = ~clk;

    ecc_stream_gen #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .mode_i      (mode),
        .byte_wide_i (bw),
        .valid_i     (valid),
        .data_i      (data),
        .code1_o     (c1),
        .code2_o     (c2),
        .done_o      (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Independent model of the code over a block of mem.
    function automatic logic [CW-1:0] ref_code(input int base, input bit joined);
        int n = joined ? NB : NB / 2;
        int nbits = joined ? AW + 1 : AW;
        logic [2*AW+1:0] lp = '0;
        logic [5:0] cp = '0;
        for (int i = 0; i < n; i++) begin
            logic p = ^mem[base + i];
            for (int k = 0; k < nbits; k++) begin
                if (((i >> k) & 1) == 1) lp[2*k+1] ^= p;
                else lp[2*k] ^= p;
            end
            for (int j = 0; j < 8; j++) begin
                if (mem[base + i][j]) begin
                    cp[j % 2] ^= 1'b1;
                    cp[2 + ((j >> 1) & 1)] ^= 1'b1;
                    cp[4 + (j >> 2)] ^= 1'b1;
                end
            end
        end
        if (joined) return {cp, lp};
        return {2'b11, cp, lp[2*AW-1:0]};
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < NB; i++) mem[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    task automatic do_clear(input logic m);
        clear = 1'b1; mode = m; tick(); clear = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        valid = 1'b1; bw = 1'b1; data = d; tick(); valid = 1'b0;
    endtask

    // Feed bytes with idle and word-wide gaps that must be ignored (R8).
    task automatic feed(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            push(mem[base + i]);
            if (i % 7 == 3) begin
                valid = 1'b1; bw = 1'b0; data = ~mem[base + i]; tick();
                bw = 1'b1; valid = 1'b0; tick();
            end
        end
    endtask

    task automatic test_reset();
        check("R1 reset code1", 32'(c1), 32'h0);
        check("R1 reset code2", 32'(c2), 32'h0);
        check("R1 reset done", 32'(done), 32'h0);
    endtask

    task automatic test_split();
        fill(11);
        do_clear(1'b0);
        feed(0, NB / 2 - 1);
        check("R2 code1 before block end", 32'(c1), 32'h0);
        feed(NB / 2 - 1, 1);
        check("R2 code1 first half", 32'(c1), 32'(ref_code(0, 0)));
        check("R5 spare bits", 32'(c1[CW-1:CW-2]), 32'h3);
        check("R7 done low mid-way", 32'(done), 32'h0);
        feed(NB / 2, NB / 2 - 1);
        check("R7 done low before last", 32'(done), 32'h0);
        feed(NB - 1, 1);
        check("R3 code2 second half", 32'(c2), 32'(ref_code(NB / 2, 0)));
        check("R7 done after last", 32'(done), 32'h1);
    endtask

    task automatic test_freeze();
        logic [CW-1:0] s1 = c1;
        logic [CW-1:0] s2 = c2;
        for (int i = 0; i < 20; i++) push(8'(i * 13 + 1));
        check("R6 code1 frozen", 32'(c1), 32'(s1));
        check("R6 code2 frozen", 32'(c2), 32'(s2));
        check("R7 done held", 32'(done), 32'h1);
        do_clear(1'b0);
        check("R1 clear code1", 32'(c1), 32'h0);
        check("R1 clear done", 32'(done), 32'h0);
    endtask

    task automatic test_joined();
        fill(97);
        do_clear(1'b1);
        mode = 1'b0;  // R10: ignored until next restart
        feed(0, NB);
        check("R4 joined code1", 32'(c1), 32'(ref_code(0, 1)));
        check("R4 joined code2 zero", 32'(c2), 32'h0);
        check("R10 layout kept", 32'(c1), 32'(ref_code(0, 1)));
        check("R7 done joined", 32'(done), 32'h1);
    endtask

    task automatic test_collision();
        fill(5);
        clear = 1'b1; mode = 1'b0; valid = 1'b1; bw = 1'b1; data = 8'hA5;
        tick();
        clear = 1'b0; valid = 1'b0;
        feed(0, NB / 2);
        check("R9 clear drops byte", 32'(c1), 32'(ref_code(0, 0)));
    endtask

    task automatic run_joined(output logic [CW-1:0] code);
        do_clear(1'b1);
        feed(0, NB);
        code = c1;
    endtask

    task automatic test_syndrome();
        logic [CW-1:0] clean, bad, syn;
        logic ok;
        int pos = 300;
        int bitn = 5;
        fill(42);
        run_joined(clean);
        mem[pos][bitn] = ~mem[pos][bitn];
        run_joined(bad);
        syn = clean ^ bad;
        ok = 1'b1;
        for (int k = 0; k <= AW; k++) begin
            if ((syn[2*k+1] ^ syn[2*k]) != 1'b1) ok = 1'b0;
            if (syn[2*k+1] != 1'(pos >> k)) ok = 1'b0;
        end
        if (syn[2*AW+3] != 1'(bitn)) ok = 1'b0;
        if (syn[2*AW+5] != 1'(bitn >> 1)) ok = 1'b0;
        if (syn[2*AW+7] != 1'(bitn >> 2)) ok = 1'b0;
        check("R11 single flip located", 32'(ok), 32'h1);
        mem[pos][bitn] = ~mem[pos][bitn];
        mem[5][2] = ~mem[5][2];
        mem[6][2] = ~mem[6][2];
        run_joined(bad);
        syn = clean ^ bad;
        check("R11 double flip ones", 32'($countones(syn)), 32'd4);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_split();
        test_freeze();
        test_joined();
        test_collision();
        test_syndrome();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule